// File: doc/BRIEF.md
# Motion Output and Start-Up Sequencer

This block drives the two external indications of a passive motion controller: a motion output and an indicator lamp. It also drives the enable that keeps the upstream pulse recognizer idle. All of its state advances only on clock edges where the slow system tick enable is high. After reset, the block runs a fixed warm-up phase. During warm-up the motion output is held low, the lamp blinks at a fixed rate whatever its enable pin says, and the recognizer enable stays low.

Once warm-up ends, each detect strobe sampled on a tick starts a fixed-length hold window. During that window the motion output is high. The lamp follows the same window, but only while the active-low lamp enable input is low. A strobe that arrives inside a hold window restarts the window at full length.

The controller has three states. SEQ_WARM is the reset state. It moves to SEQ_IDLE on the tick that completes the warm-up count. SEQ_IDLE moves to SEQ_HOLD on a ticked detect strobe. SEQ_HOLD stays in SEQ_HOLD when a ticked strobe reloads the window. It returns to SEQ_IDLE on the tick that finds the hold count spent.

Top module: `motion_out_seq`

## Requirements
- R1: While reset is asserted, and right after it is released, out_o, led_o and recog_en_o are all 0.
- R2: Warm-up lasts exactly WARM_TICKS ticks. recog_en_o is 0 before the WARM_TICKS-th tick edge, becomes 1 at that edge, and never falls again until reset.
- R3: out_o stays 0 for the whole warm-up, whatever detect does; strobes that arrive during warm-up have no effect later.
- R4: During warm-up, led_o starts at 0 and inverts on every BLINK_TICKS-th tick, so after n ticks it equals (n / BLINK_TICKS) mod 2. This holds whatever the level of led_en_n.
- R5: led_o is 0 from the tick edge that ends warm-up until a later detection drives it.
- R6: After warm-up, a detect strobe sampled high on a tick edge makes out_o 1 from that edge for exactly HOLD_TICKS tick edges. out_o is 0 again at the next tick edge after that.
- R7: During a hold window, led_o is 1 when led_en_n was 0 (lamp enabled) at the previous tick edge, and 0 when it was 1. Outside hold windows after warm-up, led_o is 0.
- R8: A detect strobe sampled during a hold window reloads the window, so out_o stays 1 for HOLD_TICKS tick edges counted from that strobe.
- R9: A change of led_en_n during a hold window shows on led_o at the next tick edge, and out_o is unaffected by it.
- R10: On clock edges where tick is 0, no output and no internal state changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick | input | 1 | Slow system tick enable, one clock wide |
| detect | input | 1 | Qualified motion strobe from the pulse recognizer |
| led_en_n | input | 1 | Lamp enable for detections, active low |
| out_o | output | 1 | Motion output |
| led_o | output | 1 | Indicator lamp drive |
| recog_en_o | output | 1 | Enable for the pulse recognizer, high after warm-up |

## Verification
Every output is a register loaded from the next-state value. Each result is therefore due at the first tick edge after the stimulus is sampled: the recognizer enable and lamp clear at the WARM_TICKS-th edge, a hold window opens at the strobe's own edge, and a lamp-enable change shows one edge later. The bench changes its inputs on falling clock edges and advances one rising edge at a time. It samples on the following falling edge, so each check reads the value of the exact tick edge it names. Hold lengths and blink phases are counted in edges from the stimulus, including the last high edge and the first low one.

// File: rtl/mseq_pkg.sv
package mseq_pkg;

    typedef enum logic [1:0] {
        SEQ_WARM = 2'd0,
        SEQ_IDLE = 2'd1,
        SEQ_HOLD = 2'd2
    } seq_state_t;

    function automatic int cnt_width(input int limit);
        return (limit > 1) ? $clog2(limit) : 1;
    endfunction

endpackage

// File: rtl/mseq_tick_count.sv
// Wrapping tick counter: counts qualified steps 0..LIMIT-1 and flags the last.
module mseq_tick_count #(
    parameter int LIMIT = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic step,
    output logic last
);
    localparam int W = mseq_pkg::cnt_width(LIMIT);
    localparam logic [W-1:0] TOP = W'(LIMIT - 1);

    logic [W-1:0] cnt_q;

    assign last = (cnt_q == TOP);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (step) begin
            if (last) begin
                cnt_q <= '0;
            end else begin
                cnt_q <= cnt_q + W'(1);
            end
        end
    end

endmodule

// File: rtl/mseq_hold_timer.sv
// Reloadable down counter for the output hold window.
module mseq_hold_timer #(
    parameter int HOLD_TICKS = 100
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    input  logic dec,
    output logic spent
);
    localparam int W = mseq_pkg::cnt_width(HOLD_TICKS);
    localparam logic [W-1:0] FULL = W'(HOLD_TICKS - 1);

    logic [W-1:0] cnt_q;

    assign spent = (cnt_q == '0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= FULL;
        end else if (dec && !spent) begin
            cnt_q <= cnt_q - W'(1);
        end
    end

endmodule

// File: rtl/motion_out_seq.sv
module motion_out_seq #(
    parameter int WARM_TICKS  = 1875,
    parameter int BLINK_TICKS = 16,
    parameter int HOLD_TICKS  = 100
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic detect,
    input  logic led_en_n,
    output logic out_o,
    output logic led_o,
    output logic recog_en_o
);
    import mseq_pkg::*;

    seq_state_t state_q;
    seq_state_t state_nxt;

    logic warm_step;
    logic warm_last;
    logic blink_last;
    logic hold_load;
    logic hold_dec;
    logic hold_spent;
    logic blink_q;
    logic blink_nxt;
    logic out_q;
    logic led_q;
    logic recog_q;

    assign warm_step = tick && (state_q == SEQ_WARM);
    assign hold_load = tick && detect && (state_q != SEQ_WARM);
    assign hold_dec  = tick && (state_q == SEQ_HOLD);

    mseq_tick_count #(.LIMIT(WARM_TICKS)) u_warm_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .step  (warm_step),
        .last  (warm_last)
    );

    mseq_tick_count #(.LIMIT(BLINK_TICKS)) u_blink_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .step  (warm_step),
        .last  (blink_last)
    );

    mseq_hold_timer #(.HOLD_TICKS(HOLD_TICKS)) u_hold (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (hold_load),
        .dec   (hold_dec),
        .spent (hold_spent)
    );

    // Next-state logic
    always_comb begin
        state_nxt = state_q;
        if (tick) begin
            unique case (state_q)
                SEQ_WARM: begin
                    if (warm_last) state_nxt = SEQ_IDLE;
                end
                SEQ_IDLE: begin
                    if (detect) state_nxt = SEQ_HOLD;
                end
                SEQ_HOLD: begin
                    if (detect)          state_nxt = SEQ_HOLD;
                    else if (hold_spent) state_nxt = SEQ_IDLE;
                end
                default: state_nxt = SEQ_WARM;
            endcase
        end
    end

    assign blink_nxt = blink_q ^ (warm_step && blink_last);

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= SEQ_WARM;
        end else begin
            state_q <= state_nxt;
        end
    end

    // Output registers, loaded from the next state on tick edges
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            blink_q <= 1'b0;
            out_q   <= 1'b0;
            led_q   <= 1'b0;
            recog_q <= 1'b0;
        end else if (tick) begin
            blink_q <= blink_nxt;
            unique case (state_nxt)
                SEQ_WARM: begin
                    out_q   <= 1'b0;
                    led_q   <= blink_nxt;
                    recog_q <= 1'b0;
                end
                SEQ_IDLE: begin
                    out_q   <= 1'b0;
                    led_q   <= 1'b0;
                    recog_q <= 1'b1;
                end
                SEQ_HOLD: begin
                    out_q   <= 1'b1;
                    led_q   <= !led_en_n;
                    recog_q <= 1'b1;
                end
                default: begin
                    out_q   <= 1'b0;
                    led_q   <= 1'b0;
                    recog_q <= 1'b0;
                end
            endcase
        end
    end

    assign out_o      = out_q;
    assign led_o      = led_q;
    assign recog_en_o = recog_q;

endmodule

// File: rtl/mseq_chk.sv
module mseq_chk (
    input logic clk,
    input logic rst_n,
    input logic tick,
    input logic detect,
    input logic led_en_n,
    input logic out_o,
    input logic led_o,
    input logic recog_en_o
);

    assert_out_low_warm_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !recog_en_o |-> !out_o);

    assert_recog_sticky_R2: assert property (@(posedge clk) disable iff (!rst_n)
        recog_en_o |=> recog_en_o);

    assert_led_clear_exit_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(recog_en_o) |-> !led_o);

    assert_led_off_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (recog_en_o && !out_o) |-> !led_o);

    assert_led_gated_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && recog_en_o && led_en_n) |=> !led_o);

    assert_strobe_holds_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && recog_en_o && detect) |=> out_o);

    assert_no_tick_stable_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> ($stable(out_o) && $stable(led_o) && $stable(recog_en_o)));

endmodule

bind motion_out_seq mseq_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick       (tick),
    .detect     (detect),
    .led_en_n   (led_en_n),
    .out_o      (out_o),
    .led_o      (led_o),
    .recog_en_o (recog_en_o)
);

// File: tb/motion_out_seq_tb.sv
module motion_out_seq_tb;

    localparam int CLK_PERIOD = 10;
    localparam int WARM  = 1875;
    localparam int BLINK = 16;
    localparam int HOLD  = 100;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tick = 1'b1;
    logic detect = 1'b0;
    logic led_en_n = 1'b1;
    logic out_o;
    logic led_o;
    logic recog_en_o;

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    motion_out_seq #(
        .WARM_TICKS  (WARM),
        .BLINK_TICKS (BLINK),
        .HOLD_TICKS  (HOLD)
    ) u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick       (tick),
        .detect     (detect),
        .led_en_n   (led_en_n),
        .out_o      (out_o),
        .led_o      (led_o),
        .recog_en_o (recog_en_o)
    );

    task automatic check(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // advance n rising edges, return on the following falling edge
    task automatic step(input int n);
        for (int k = 0; k < n; k++) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic t_reset();
        check("R1", "out in reset", out_o, 0);
        check("R1", "led in reset", led_o, 0);
        check("R1", "recog in reset", recog_en_o, 0);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", "out after release", out_o, 0);
        check("R1", "recog after release", recog_en_o, 0);
    endtask

    // one rising edge has passed since release with tick high
    task automatic t_warmup();
        int out_bad = 0;
        int recog_bad = 0;
        int led_bad = 0;
        detect = 1'b1;
        led_en_n = 1'b1;
        if (led_o != 0) led_bad++;
        for (int i = 2; i < WARM; i++) begin
            if (i == BLINK * 40) led_en_n = 1'b0;
            step(1);
            if (out_o != 0) out_bad++;
            if (recog_en_o != 0) recog_bad++;
            if (led_o != ((i / BLINK) % 2)) led_bad++;
        end
        check("R3", "out high during warm-up count", out_bad, 0);
        check("R2", "recog high during warm-up count", recog_bad, 0);
        check("R4", "blink pattern mismatches", led_bad, 0);
        check("R4", "led at tick WARM-1", led_o, ((WARM - 1) / BLINK) % 2);
        detect = 1'b0;
        led_en_n = 1'b1;
        step(1);
        check("R2", "recog at end of warm-up", recog_en_o, 1);
        check("R5", "led at end of warm-up", led_o, 0);
        check("R3", "out after warm-up with earlier strobes", out_o, 0);
        step(5);
        check("R5", "led idle after warm-up", led_o, 0);
        check("R3", "out idle after warm-up", out_o, 0);
    endtask

    task automatic t_hold_enabled();
        led_en_n = 1'b0;
        detect = 1'b1;
        step(1);
        detect = 1'b0;
        check("R6", "out at strobe edge", out_o, 1);
        check("R7", "led at strobe edge, enabled", led_o, 1);
        step(HOLD - 1);
        check("R6", "out at last hold edge", out_o, 1);
        check("R7", "led at last hold edge", led_o, 1);
        step(1);
        check("R6", "out after hold", out_o, 0);
        check("R7", "led after hold", led_o, 0);
        check("R2", "recog stays high", recog_en_o, 1);
    endtask

    task automatic t_hold_disabled();
        led_en_n = 1'b1;
        detect = 1'b1;
        step(1);
        detect = 1'b0;
        check("R6", "out with lamp disabled", out_o, 1);
        check("R7", "led with lamp disabled", led_o, 0);
        step(10);
        led_en_n = 1'b0;
        check("R9", "led before enable edge", led_o, 0);
        step(1);
        check("R9", "led one edge after enable", led_o, 1);
        check("R9", "out unaffected by enable", out_o, 1);
        led_en_n = 1'b1;
        step(1);
        check("R9", "led one edge after disable", led_o, 0);
        check("R9", "out unaffected by disable", out_o, 1);
        step(HOLD - 13);
        check("R6", "out at last edge", out_o, 1);
        step(1);
        check("R6", "out clears", out_o, 0);
    endtask

    task automatic t_retrigger();
        led_en_n = 1'b0;
        detect = 1'b1;
        step(1);
        detect = 1'b0;
        step(60);
        detect = 1'b1;
        step(1);
        detect = 1'b0;
        check("R8", "out at retrigger", out_o, 1);
        step(HOLD - 1);
        check("R8", "out held by reload", out_o, 1);
        check("R8", "led held by reload", led_o, 1);
        step(1);
        check("R8", "out clears after reload window", out_o, 0);
    endtask

    task automatic t_no_tick();
        tick = 1'b0;
        detect = 1'b1;
        led_en_n = 1'b0;
        step(20);
        check("R10", "out without tick", out_o, 0);
        check("R10", "led without tick", led_o, 0);
        detect = 1'b0;
        tick = 1'b1;
        step(1);
        check("R10", "out after idle clocks", out_o, 0);
        detect = 1'b1;
        step(1);
        detect = 1'b0;
        tick = 1'b0;
        step(HOLD + 10);
        check("R10", "out frozen high without tick", out_o, 1);
        tick = 1'b1;
        step(HOLD - 1);
        check("R6", "out last edge after pause", out_o, 1);
        step(1);
        check("R6", "out clears after pause", out_o, 0);
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        checks++;
        failures++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        finish_run();
    end

    initial begin
        step(2);
        t_reset();
        t_warmup();
        t_hold_enabled();
        t_hold_disabled();
        t_retrigger();
        t_no_tick();
        finish_run();
    end

endmodule